// File: doc/BRIEF.md
# Operand-Stack Bytecode Engine

This block interprets a small set of stack-machine bytecodes. After a start pulse it reads one code byte per clock from a byte-wide code memory, beginning at address zero. A few opcodes carry a one-byte inline operand in the byte that follows them. Other opcodes encode the local-variable slot they use in the opcode value itself. Arithmetic operands live on a 32-bit operand stack of parameterised depth. Results are stored into an array of 32-bit local slots.

The engine stops when it reaches the return opcode and then holds `done`. It also stops on a fault: an opcode it does not know, a pop that needs more entries than the stack holds, or a push onto a full stack. A fault holds `err`. In both stopped states the code address is frozen, and the state stays put until the next start pulse. The local slots and the current stack depth are brought out on ports so that the surrounding logic can observe them.

Top module: `bcx_engine`

## Requirements
- R1: A start pulse has priority over any instruction in that cycle. On the next cycle `code_addr` is 0, `depth` is 0, `busy` is 1, and `done` and `err` are 0.
- R2: Opcode 0x10 takes two cycles. It pushes the following code byte, sign-extended to 32 bits, and advances `code_addr` by 2. Every other opcode takes one cycle, so a program of N bytes ending in a return raises `done` N cycles after the start cycle.
- R3: Opcode 0x03 pushes the value 0.
- R4: Opcodes 0x3C, 0x3D and 0x3E pop the top entry into local slot 1, 2 and 3 respectively. Slot i appears on `locals_flat[32*i+31:32*i]`. Slot 0 is never written.
- R5: Opcodes 0x1B and 0x1C push the contents of local slot 1 and slot 2 respectively.
- R6: Opcode 0x60 replaces the top two entries with their sum modulo 2^32, so the depth drops by one.
- R7: Opcode 0xB1 sets `done` and clears `busy`. After that, `code_addr` stays at the address of the return byte.
- R8: Any opcode outside the set above sets `err` and halts. `code_addr` stays on the faulting byte, and neither the locals nor the depth change.
- R9: A store with an empty stack, or an add with fewer than two entries, sets `err` and halts. The depth is left unchanged.
- R10: A push of any kind onto a stack holding DEPTH entries (default 2) sets `err` and halts. The depth stays at DEPTH.
- R11: `err` and `done` persist until the next start pulse. A start pulse clears both but leaves the local slots as they were.
- R12: After reset, `busy`, `done` and `err` are 0, `depth` is 0 and every local slot is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that restarts the program from address 0 |
| code_addr | output | PC_W | Address of the code byte being read |
| code_byte | input | 8 | Code byte at `code_addr`, valid in the same cycle |
| busy | output | 1 | Engine is executing |
| done | output | 1 | Return opcode reached |
| err | output | 1 | Sticky fault flag |
| depth | output | $clog2(DEPTH+1) | Number of stack entries |
| locals_flat | output | NLOC*32 | All local slots, with slot 0 in the low bits |

## Verification
The sharpest overlap is a start pulse that arrives in the same cycle as an instruction that would write a local slot and pop the stack. The bench runs a short program of push followed by store, and raises start exactly on the cycle in which the store byte is presented. It then checks that the slot still holds its earlier value, that the depth is 0 and that the code address is back at 0. Finally it lets the restarted program finish and checks that the store then lands. A second overlap is the add, which reads two entries, pops both and pushes one in a single cycle. This is judged through wrap-around and sign-extended sums stored to slots.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

   typedef enum logic [2:0] {
      K_PUSH_IMM,
      K_PUSH_ZERO,
      K_STORE,
      K_LOAD,
      K_ADD,
      K_RET,
      K_BAD
   } kind_e;

   typedef enum logic [1:0] {
      S_NONE,
      S_PUSH,
      S_POP,
      S_ADD
   } sop_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUN,
      ST_IMM,
      ST_DONE,
      ST_FAULT
   } state_e;

   localparam logic [7:0] OPC_IMM8 = 8'h10;
   localparam logic [7:0] OPC_ZERO = 8'h03;
   localparam logic [7:0] OPC_ST1  = 8'h3C;
   localparam logic [7:0] OPC_ST2  = 8'h3D;
   localparam logic [7:0] OPC_ST3  = 8'h3E;
   localparam logic [7:0] OPC_LD1  = 8'h1B;
   localparam logic [7:0] OPC_LD2  = 8'h1C;
   localparam logic [7:0] OPC_SUM  = 8'h60;
   localparam logic [7:0] OPC_RET  = 8'hB1;

endpackage

// File: rtl/bcx_decode.sv
module bcx_decode
   import bcx_pkg::*;
(
   input  logic [7:0] opc,
   output kind_e      kind,
   output logic [1:0] slot
);

   always_comb begin
      kind = K_BAD;
      slot = 2'd0;
      case (opc)
         OPC_IMM8: kind = K_PUSH_IMM;
         OPC_ZERO: kind = K_PUSH_ZERO;
         OPC_ST1:  begin kind = K_STORE; slot = 2'd1; end
         OPC_ST2:  begin kind = K_STORE; slot = 2'd2; end
         OPC_ST3:  begin kind = K_STORE; slot = 2'd3; end
         OPC_LD1:  begin kind = K_LOAD;  slot = 2'd1; end
         OPC_LD2:  begin kind = K_LOAD;  slot = 2'd2; end
         OPC_SUM:  kind = K_ADD;
         OPC_RET:  kind = K_RET;
         default:  kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/bcx_opstack.sv
module bcx_opstack
   import bcx_pkg::*;
#(
   parameter int W     = 32,
   parameter int DEPTH = 2,
   localparam int DW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  sop_e          op,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  top,
   output logic [DW-1:0] depth,
   output logic          empty,
   output logic          full,
   output logic          has_two
);

   logic [W-1:0]  mem [DEPTH];
   logic [DW-1:0] cnt;
   logic [DW-1:0] cm1;
   logic [DW-1:0] cm2;
   logic [W-1:0]  below;

   assign cm1     = cnt - DW'(1);
   assign cm2     = cnt - DW'(2);
   assign top     = mem[cm1[IW-1:0]];
   assign below   = mem[cm2[IW-1:0]];
   assign depth   = cnt;
   assign empty   = (cnt == '0);
   assign full    = (cnt == DW'(DEPTH));
   assign has_two = (cnt >= DW'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else begin
         case (op)
            S_PUSH: begin
               mem[cnt[IW-1:0]] <= wdata;
               cnt <= cnt + DW'(1);
            end
            S_POP: cnt <= cm1;
            S_ADD: begin
               mem[cm2[IW-1:0]] <= top + below;
               cnt <= cm1;
            end
            default: ;
         endcase
      end
   end

   p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DW'(DEPTH));
   p_push_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op == S_PUSH) |-> !full);
   p_pop_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op == S_POP) |-> !empty);
   p_add_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op == S_ADD) |=> depth == $past(depth) - DW'(1));

endmodule

// File: rtl/bcx_locals.sv
module bcx_locals #(
   parameter int W    = 32,
   parameter int NLOC = 4,
   localparam int LW  = $clog2(NLOC)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [LW-1:0]   waddr,
   input  logic [W-1:0]    wdata,
   input  logic [LW-1:0]   raddr,
   output logic [W-1:0]    rdata,
   output logic [NLOC*W-1:0] flat
);

   logic [W-1:0] slot_q [NLOC];

   for (genvar g = 0; g < NLOC; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          slot_q[g] <= '0;
         else if (we && waddr == LW'(g))      slot_q[g] <= wdata;
      end
      assign flat[g*W +: W] = slot_q[g];
   end

   assign rdata = slot_q[raddr];

   p_no_slot0_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> waddr != '0);
   p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> flat[$past(waddr)*W +: W] == $past(wdata));

endmodule

// File: rtl/bcx_engine.sv
module bcx_engine
   import bcx_pkg::*;
#(
   parameter int PC_W     = 8,
   parameter int DEPTH    = 2,
   parameter int NLOC     = 4,
   parameter bit SEXT_IMM = 1'b1,
   localparam int W       = 32,
   localparam int DW      = $clog2(DEPTH + 1),
   localparam int LW      = $clog2(NLOC)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic [PC_W-1:0]    code_addr,
   input  logic [7:0]         code_byte,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic [DW-1:0]      depth,
   output logic [NLOC*W-1:0]  locals_flat
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("bcx_engine: DEPTH must be at least 2");
   end
   if (NLOC < 4) begin : g_bad_nloc
      $error("bcx_engine: NLOC must be at least 4");
   end
   if (PC_W < 2) begin : g_bad_pcw
      $error("bcx_engine: PC_W must be at least 2");
   end

   state_e          state, nxt_state;
   logic [PC_W-1:0] pc, nxt_pc;
   kind_e           kind;
   logic [1:0]      dslot;
   sop_e            sop;
   logic [W-1:0]    push_val;
   logic [W-1:0]    imm_ext;
   logic [W-1:0]    top;
   logic [W-1:0]    ld_val;
   logic            st_empty, st_full, st_two;
   logic            lwe;

   bcx_decode u_dec (
      .opc  (code_byte),
      .kind (kind),
      .slot (dslot)
   );

   if (SEXT_IMM) begin : g_sext
      assign imm_ext = {{(W-8){code_byte[7]}}, code_byte};
   end else begin : g_zext
      assign imm_ext = {{(W-8){1'b0}}, code_byte};
   end

   bcx_opstack #(.W(W), .DEPTH(DEPTH)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .op      (sop),
      .wdata   (push_val),
      .top     (top),
      .depth   (depth),
      .empty   (st_empty),
      .full    (st_full),
      .has_two (st_two)
   );

   bcx_locals #(.W(W), .NLOC(NLOC)) u_loc (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lwe),
      .waddr (LW'(dslot)),
      .wdata (top),
      .raddr (LW'(dslot)),
      .rdata (ld_val),
      .flat  (locals_flat)
   );

   always_comb begin
      nxt_state = state;
      nxt_pc    = pc;
      sop       = S_NONE;
      push_val  = '0;
      lwe       = 1'b0;
      if (!start) begin
         case (state)
            ST_RUN: begin
               case (kind)
                  K_PUSH_IMM: begin
                     nxt_state = ST_IMM;
                     nxt_pc    = pc + PC_W'(1);
                  end
                  K_PUSH_ZERO: begin
                     if (st_full) nxt_state = ST_FAULT;
                     else begin
                        sop    = S_PUSH;
                        nxt_pc = pc + PC_W'(1);
                     end
                  end
                  K_STORE: begin
                     if (st_empty) nxt_state = ST_FAULT;
                     else begin
                        sop    = S_POP;
                        lwe    = 1'b1;
                        nxt_pc = pc + PC_W'(1);
                     end
                  end
                  K_LOAD: begin
                     if (st_full) nxt_state = ST_FAULT;
                     else begin
                        sop      = S_PUSH;
                        push_val = ld_val;
                        nxt_pc   = pc + PC_W'(1);
                     end
                  end
                  K_ADD: begin
                     if (!st_two) nxt_state = ST_FAULT;
                     else begin
                        sop    = S_ADD;
                        nxt_pc = pc + PC_W'(1);
                     end
                  end
                  K_RET:   nxt_state = ST_DONE;
                  default: nxt_state = ST_FAULT;
               endcase
            end
            ST_IMM: begin
               if (st_full) nxt_state = ST_FAULT;
               else begin
                  sop       = S_PUSH;
                  push_val  = imm_ext;
                  nxt_pc    = pc + PC_W'(1);
                  nxt_state = ST_RUN;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pc    <= '0;
      end else if (start) begin
         state <= ST_RUN;
         pc    <= '0;
      end else begin
         state <= nxt_state;
         pc    <= nxt_pc;
      end
   end

   assign code_addr = pc;
   assign busy      = (state == ST_RUN) || (state == ST_IMM);
   assign done      = (state == ST_DONE);
   assign err       = (state == ST_FAULT);

   p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (depth == '0 && code_addr == '0 && !err && !done && busy));
   p_imm_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && state == ST_RUN && kind == K_PUSH_IMM) |=>
         (state == ST_IMM && code_addr == $past(code_addr) + PC_W'(1)));
   p_halt_pc_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((done || err) && !start) |=> $stable(code_addr));
   p_sticky_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !start) |=> err);
   p_bad_opcode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && state == ST_RUN && kind == K_BAD) |=>
         (err && $stable(depth) && $stable(locals_flat)));
   p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, done, err}));

endmodule

// File: tb/test_bcx_engine.sv
`timescale 1ns/1ps
module test_bcx_engine;

   localparam int PC_W  = 8;
   localparam int DEPTH = 2;
   localparam int NLOC  = 4;
   localparam int DW    = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [PC_W-1:0]   code_addr;
   logic [7:0]        code_byte;
   logic              busy, done, err;
   logic [DW-1:0]     depth;
   logic [NLOC*32-1:0] locals_flat;

   logic [7:0] mem [256];
   int n_chk = 0;
   int n_bad = 0;
   bit reported = 1'b0;
   logic [31:0] xl [NLOC];

   assign code_byte = mem[code_addr];

   always #10 clk = ~clk;

   bcx_engine #(.PC_W(PC_W), .DEPTH(DEPTH), .NLOC(NLOC)) i_bcx_engine (
      .clk (clk), .rst_n (rst_n), .start (start),
      .code_addr (code_addr), .code_byte (code_byte),
      .busy (busy), .done (done), .err (err),
      .depth (depth), .locals_flat (locals_flat)
   );

   function automatic logic [31:0] lv(int i);
      return locals_flat[i*32 +: 32];
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_locals(string req);
      for (int i = 0; i < NLOC; i++) chk(req, $sformatf("local%0d", i), lv(i), xl[i]);
   endtask

   task automatic load(logic [127:0] bytes, int n);
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      for (int i = 0; i < n; i++) mem[i] = bytes[8*(n-1-i) +: 8];
   endtask

   task automatic go(output int ncyc);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R1", "addr after start", 32'(code_addr), 32'd0);
      chk("R11", "err/done after start", {30'd0, err, done}, 32'd0);
      ncyc = 0;
      while (busy && ncyc < 100) begin
         @(negedge clk);
         ncyc++;
      end
   endtask

   task automatic t_reset;
      chk("R12", "flags after reset", {29'd0, busy, done, err}, 32'd0);
      chk("R12", "depth after reset", 32'(depth), 32'd0);
      chk_locals("R12");
   endtask

   task automatic t_reference;
      int n;
      load({8'h10,8'h0F,8'h3C,8'h10,8'h09,8'h3D,8'h03,8'h3E,8'h1B,8'h1C,8'h60,8'h3E,8'hB1}, 13);
      go(n);
      xl[1] = 32'd15; xl[2] = 32'd9; xl[3] = 32'd24;
      chk("R2", "cycles for 13 bytes", 32'(n), 32'd13);
      chk("R7", "done", {31'd0, done}, 32'd1);
      chk("R6", "err", {31'd0, err}, 32'd0);
      chk_locals("R4");
      chk("R3", "depth", 32'(depth), 32'd0);
   endtask

   task automatic t_sext;
      int n;
      load({8'h10,8'hFF,8'h10,8'h03,8'h60,8'h3C,8'h10,8'h80,8'h3D,8'hB1}, 10);
      go(n);
      xl[1] = 32'd2; xl[2] = 32'hFFFF_FF80;
      chk("R2", "cycles", 32'(n), 32'd10);
      chk_locals("R2");
   endtask

   task automatic t_wrap;
      int n;
      load({8'h10,8'hFF,8'h10,8'hFF,8'h60,8'h3E,8'hB1}, 7);
      go(n);
      xl[3] = 32'hFFFF_FFFE;
      chk_locals("R6");
      repeat (4) @(negedge clk);
      chk("R7", "addr held on return", 32'(code_addr), 32'd6);
      chk("R7", "done held", {30'd0, busy, done}, 32'd1);
   endtask

   task automatic t_swap;
      int n;
      logic [31:0] a;
      load({8'h1B,8'h1C,8'h3C,8'h3D,8'hB1}, 5);
      go(n);
      a = xl[1]; xl[1] = xl[2]; xl[2] = a;
      chk_locals("R5");
   endtask

   task automatic t_bad_opcode;
      int n;
      load({8'h10,8'h07,8'h3D,8'h5A,8'h3C,8'hB1}, 6);
      go(n);
      xl[2] = 32'd7;
      chk("R8", "err", {30'd0, done, err}, 32'd1);
      chk("R8", "addr on bad byte", 32'(code_addr), 32'd3);
      chk("R8", "depth", 32'(depth), 32'd0);
      chk_locals("R8");
      repeat (5) @(negedge clk);
      chk("R11", "err sticky", {31'd0, err}, 32'd1);
      chk("R11", "addr held", 32'(code_addr), 32'd3);
   endtask

   task automatic t_underflow;
      int n;
      load({8'h3C,8'hB1}, 2);
      go(n);
      chk("R9", "store on empty err", {31'd0, err}, 32'd1);
      chk("R9", "depth", 32'(depth), 32'd0);
      chk("R9", "addr", 32'(code_addr), 32'd0);
      chk_locals("R9");
      load({8'h10,8'h01,8'h60,8'hB1}, 4);
      go(n);
      chk("R9", "add on one entry err", {31'd0, err}, 32'd1);
      chk("R9", "depth kept", 32'(depth), 32'd1);
      chk("R9", "addr", 32'(code_addr), 32'd2);
   endtask

   task automatic t_overflow;
      int n;
      load({8'h10,8'h01,8'h10,8'h02,8'h03,8'hB1}, 6);
      go(n);
      chk("R10", "zero push on full", {31'd0, err}, 32'd1);
      chk("R10", "depth", 32'(depth), 32'd2);
      chk("R10", "addr", 32'(code_addr), 32'd4);
      load({8'h10,8'h01,8'h10,8'h02,8'h1B,8'hB1}, 6);
      go(n);
      chk("R10", "load push on full", {31'd0, err}, 32'd1);
      chk("R10", "depth", 32'(depth), 32'd2);
      load({8'h03,8'h03,8'h10,8'h05,8'hB1}, 5);
      go(n);
      chk("R10", "imm push on full", {31'd0, err}, 32'd1);
      chk("R10", "addr on operand", 32'(code_addr), 32'd3);
      chk_locals("R10");
   endtask

   task automatic t_collision;
      int n;
      load({8'h10,8'h05,8'h3C,8'hB1}, 4);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "store byte presented", 32'(code_addr), 32'd2);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R1", "store suppressed by start", lv(1), xl[1]);
      chk("R1", "depth cleared by start", 32'(depth), 32'd0);
      chk("R1", "addr restarted", 32'(code_addr), 32'd0);
      n = 0;
      while (busy && n < 100) begin @(negedge clk); n++; end
      xl[1] = 32'd5;
      chk("R4", "store after restart", lv(1), xl[1]);
      chk("R7", "done after restart", {31'd0, done}, 32'd1);
   endtask

   initial begin
      for (int i = 0; i < NLOC; i++) xl[i] = 32'd0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reference();
      t_sext();
      t_wrap();
      t_swap();
      t_bad_opcode();
      t_underflow();
      t_overflow();
      t_reference();
      t_collision();
      if (!reported) begin
         reported = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!reported) begin
         reported = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
      $finish;
   end

endmodule